// File: doc/BRIEF.md
# Automatic Node-Sync Controller

This block decides when the grouping of received code symbols into per-bit sets has slipped. It watches one of two decoder health indications: traceback disagreements, signalled by an active-low line, or path-metric renormalizations, signalled by an active-high line. It counts the selected indication over windows of 256 decoded bits. A 3-bit code sets a power-of-two limit. When the running count within a window goes past that limit, the controller steps its 2-bit grouping phase to the next candidate and raises a one-cycle flag.

The phase sequence depends on the code rate. With two symbols per bit there are two candidate groupings. With three symbols per bit there are three, and the fourth code value is never produced. An enable selects the value that the symbol reorder logic downstream actually uses. When it is set, that value is the internally tracked phase. When it is clear, it is a pair of manually supplied bits. The live count is always visible, so firmware can tune the threshold against the link's noise level.

Top module: `node_sync_ctrl`

## Requirements
- R1: After reset, `evt_count`, `sync_state` and `sync_flip` are all zero.
- R2: When `mis_sel`=1, a strobe with `mismatch_n`=0 counts as an event and `renorm` is ignored. When `mis_sel`=0, a strobe with `renorm`=1 counts as an event and `mismatch_n` is ignored.
- R3: Event lines are sampled only in cycles where `bit_stb`=1. In any cycle without a strobe, the count, the phase and the window position stay unchanged.
- R4: The limit is 2^`thr_code` (1 to 128). A strobe whose event brings the count above the limit is the advancing strobe. For an uninterrupted run of events, this is the (2^code+1)-th event.
- R5: On an advancing strobe the count returns to zero, and a fresh 256-bit window starts.
- R6: Windows are 256 strobes long. After the 256th strobe of a window, the count reads zero unless that strobe advanced.
- R7: When `rate_third`=0, each advance moves the phase 0->1 and 1->0. Phases 2 or 3 go to 0.
- R8: When `rate_third`=1, each advance moves the phase 0->1->2->0. Phase code 3 is never produced.
- R9: The register outputs update one clock after the strobe. `sync_flip` is high for exactly that one cycle after an advancing strobe, along with the new phase.
- R10: `sync_eff` equals `sync_state` when `auto_en`=1 and `manual_sync` when `auto_en`=0, with no delay.
- R11: Every non-advancing strobe, other than the last of a window, updates `evt_count` to the previous count plus the event, saturating at 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe per decoded bit |
| mis_sel | input | 1 | Event source: 1 = traceback disagreement, 0 = renormalization |
| mismatch_n | input | 1 | Traceback disagreement, active low |
| renorm | input | 1 | Metric renormalization, active high |
| thr_code | input | 3 | Threshold exponent; limit is 2^code |
| auto_en | input | 1 | Use internal phase for `sync_eff` |
| manual_sync | input | 2 | Manually chosen phase |
| rate_third | input | 1 | 1 = three symbols per bit, 0 = two |
| sync_state | output | 2 | Internally tracked grouping phase |
| sync_eff | output | 2 | Phase handed to the symbol reorder logic |
| sync_flip | output | 1 | One-cycle pulse when the phase steps |
| evt_count | output | 8 | Live event count in the current window |

## Verification
Every threshold code is swept with an unbroken run of events. This shows whether the advance lands exactly on the event after the limit, and separates an off-by-one compare (>= versus >) from a wrong exponent decode. Strobes are also issued with only the unselected line active, and event lines are held active between strobes. These patterns separate a wrong source mux from missing strobe qualification. A sparse event stream across several full windows, with every other bit carrying an event, shows that the count clears at each window boundary without advancing the phase. Long advance chains are run in both rates, including a rate change while the phase sits at 2, to expose wrong phase cycling or entry into the invalid code.

// File: rtl/nsync_pkg.sv
package nsync_pkg;

  typedef enum logic [1:0] {PH0 = 2'd0, PH1 = 2'd1, PH2 = 2'd2, PH_BAD = 2'd3} phase_t;

  // limit for a threshold exponent
  function automatic int thr_value(input int code);
    return 1 << code;
  endfunction

  // add with ceiling
  function automatic int sat_add(input int v, input int inc, input int maxv);
    int s;
    s = v + inc;
    return (s > maxv) ? maxv : s;
  endfunction

  // next candidate grouping for the given rate
  function automatic phase_t next_phase(input phase_t s, input logic third);
    if (!third) return (s == PH0) ? PH1 : PH0;
    case (s)
      PH0:     return PH1;
      PH1:     return PH2;
      default: return PH0;
    endcase
  endfunction

endpackage

// File: rtl/nsync_evt_sel.sv
module nsync_evt_sel (
  input  logic bit_stb,
  input  logic mis_sel,
  input  logic mismatch_n,
  input  logic renorm,
  output logic evt
);
  logic picked;
  assign picked = mis_sel ? ~mismatch_n : renorm;
  assign evt    = bit_stb & picked;
endmodule

// File: rtl/nsync_window.sv
module nsync_window #(
  parameter int WIN_LOG = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic restart,
  output logic win_last
);
  logic [WIN_LOG-1:0] idx;

  assign win_last = (idx == {WIN_LOG{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (bit_stb) idx <= restart ? '0 : idx + 1'b1;
  end

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && restart) |=> (idx == '0));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(idx));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && win_last) |=> (idx == '0));
endmodule

// File: rtl/nsync_counter.sv
module nsync_counter
  import nsync_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int THR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             evt,
  input  logic             win_last,
  input  logic [THR_W-1:0] thr_code,
  output logic             exceed,
  output logic [CNT_W-1:0] count
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_next;

  assign cnt_next = CNT_W'(sat_add(int'(count), int'(evt), CNT_MAX));
  assign exceed   = bit_stb && (int'(cnt_next) > thr_value(int'(thr_code)));

  always_ff @(posedge clk) begin
    if (!rst_n)                   count <= '0;
    else if (bit_stb) begin
      if (exceed || win_last)     count <= '0;
      else                        count <= cnt_next;
    end
  end

  assert_clear_after_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exceed |=> (count == '0));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(count));
  assert_window_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && win_last) |=> (count == '0));
  assert_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !exceed && !win_last && count != CNT_W'(CNT_MAX))
      |=> (count == $past(count) + CNT_W'($past(evt))));
endmodule

// File: rtl/nsync_phase.sv
module nsync_phase
  import nsync_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   advance,
  input  logic   third,
  output phase_t state,
  output logic   flip
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PH0;
      flip  <= 1'b0;
    end else begin
      flip <= advance;
      if (advance) state <= next_phase(state, third);
    end
  end

  assert_third_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && third) |=> (state != PH_BAD));
  assert_half_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !third) |=> (state == PH0 || state == PH1));
  assert_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (state != $past(state)));
  assert_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(state));
endmodule

// File: rtl/node_sync_ctrl.sv
module node_sync_ctrl
  import nsync_pkg::*;
#(
  parameter int WIN_LOG = 8,
  parameter int CNT_W   = 8,
  parameter int THR_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             mis_sel,
  input  logic             mismatch_n,
  input  logic             renorm,
  input  logic [THR_W-1:0] thr_code,
  input  logic             auto_en,
  input  logic [1:0]       manual_sync,
  input  logic             rate_third,
  output logic [1:0]       sync_state,
  output logic [1:0]       sync_eff,
  output logic             sync_flip,
  output logic [CNT_W-1:0] evt_count
);
  logic   evt;
  logic   win_last;
  logic   exceed;
  phase_t phase;

  nsync_evt_sel u_sel (
    .bit_stb(bit_stb), .mis_sel(mis_sel), .mismatch_n(mismatch_n),
    .renorm(renorm), .evt(evt)
  );

  nsync_window #(.WIN_LOG(WIN_LOG)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb),
    .restart(exceed), .win_last(win_last)
  );

  nsync_counter #(.CNT_W(CNT_W), .THR_W(THR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .evt(evt),
    .win_last(win_last), .thr_code(thr_code),
    .exceed(exceed), .count(evt_count)
  );

  nsync_phase u_ph (
    .clk(clk), .rst_n(rst_n), .advance(exceed),
    .third(rate_third), .state(phase), .flip(sync_flip)
  );

  assign sync_state = phase;
  assign sync_eff   = auto_en ? sync_state : manual_sync;

  assert_no_evt_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |-> !evt);
  assert_flip_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flip |=> !sync_flip);
  assert_flip_count_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sync_flip |-> (evt_count == '0));
endmodule

// File: tb/tb_node_sync_ctrl.sv
module tb_node_sync_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0;
  logic       mis_sel = 1'b1;
  logic       mismatch_n = 1'b1;
  logic       renorm = 1'b0;
  logic [2:0] thr_code = 3'd0;
  logic       auto_en = 1'b1;
  logic [1:0] manual_sync = 2'd0;
  logic       rate_third = 1'b0;
  logic [1:0] sync_state;
  logic [1:0] sync_eff;
  logic       sync_flip;
  logic [7:0] evt_count;

  int n_chk = 0;
  int n_bad = 0;
  int m_cnt = 0;
  int m_idx = 0;
  int m_state = 0;
  bit done = 0;

  always #10 clk = ~clk;

  node_sync_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .mis_sel(mis_sel),
    .mismatch_n(mismatch_n), .renorm(renorm), .thr_code(thr_code),
    .auto_en(auto_en), .manual_sync(manual_sync), .rate_third(rate_third),
    .sync_state(sync_state), .sync_eff(sync_eff), .sync_flip(sync_flip),
    .evt_count(evt_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one strobe cycle followed by one idle cycle; model updated and compared
  task automatic strobe(input logic mm_n, input logic rn);
    int  e;
    int  nxt;
    bit  adv;
    bit  wrapped;
    @(negedge clk);
    bit_stb = 1'b1; mismatch_n = mm_n; renorm = rn;
    e   = mis_sel ? (mm_n ? 0 : 1) : (rn ? 1 : 0);
    nxt = m_cnt + e;
    if (nxt > 255) nxt = 255;
    adv = 0; wrapped = 0;
    if (nxt > 2 ** int'(thr_code)) begin
      adv = 1; m_cnt = 0; m_idx = 0;
      if (rate_third) m_state = (m_state >= 2) ? 0 : m_state + 1;
      else            m_state = (m_state == 0) ? 1 : 0;
    end else if (m_idx == 255) begin
      wrapped = 1; m_cnt = 0; m_idx = 0;
    end else begin
      m_cnt = nxt; m_idx = m_idx + 1;
    end
    @(negedge clk);
    bit_stb = 1'b0; mismatch_n = 1'b1; renorm = 1'b0;
    chk("R11", "count", int'(evt_count), m_cnt);
    chk("R9", "flip", int'(sync_flip), int'(adv));
    chk(rate_third ? "R8" : "R7", "phase", int'(sync_state), m_state);
    if (wrapped) chk("R6", "count at window end", int'(evt_count), 0);
  endtask

  task automatic idle(input int n, input logic mm_n, input logic rn);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mismatch_n = mm_n; renorm = rn;
      chk("R3", "count idle", int'(evt_count), m_cnt);
      chk("R3", "phase idle", int'(sync_state), m_state);
    end
    @(negedge clk);
    mismatch_n = 1'b1; renorm = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "count", int'(evt_count), 0);
    chk("R1", "phase", int'(sync_state), 0);
    chk("R1", "flip", int'(sync_flip), 0);

    // R4: sweep every threshold code with uninterrupted events
    mis_sel = 1'b1; rate_third = 1'b0;
    for (int c = 0; c < 8; c++) begin
      thr_code = 3'(c);
      for (int k = 0; k < 2 ** c; k++) strobe(1'b0, 1'b0);
      chk("R4", "no advance at limit", int'(sync_flip), 0);
      strobe(1'b0, 1'b0);
      chk("R4", "advance after limit", int'(sync_flip), 1);
      chk("R5", "count after advance", int'(evt_count), 0);
    end

    // R2: unselected line ignored, selected line counted
    thr_code = 3'd7;
    for (int k = 0; k < 5; k++) strobe(1'b1, 1'b1);
    chk("R2", "renorm ignored", int'(evt_count), 0);
    mis_sel = 1'b0;
    for (int k = 0; k < 5; k++) strobe(1'b0, 1'b0);
    chk("R2", "mismatch ignored", int'(evt_count), 0);
    for (int k = 0; k < 3; k++) strobe(1'b1, 1'b1);
    chk("R2", "renorm counted", int'(evt_count), 3);

    // R3: active event lines without strobe
    idle(6, 1'b0, 1'b1);
    chk("R3", "count held", int'(evt_count), 3);

    // R6: sparse events across several windows, no advance
    for (int k = 0; k < 600; k++) strobe(1'b1, (k % 2) == 0);
    chk("R6", "phase unchanged", int'(sync_state), m_state);

    // R8: three-phase chain
    rate_third = 1'b1; thr_code = 3'd0;
    for (int a = 0; a < 7; a++) begin
      strobe(1'b1, 1'b1); strobe(1'b1, 1'b1);
      chk("R8", "valid phase", int'(sync_state == 2'd3), 0);
    end
    while (m_state != 2) begin strobe(1'b1, 1'b1); strobe(1'b1, 1'b1); end

    // R7: switch to two-phase while at phase 2
    rate_third = 1'b0;
    strobe(1'b1, 1'b1); strobe(1'b1, 1'b1);
    chk("R7", "phase 2 to 0", int'(sync_state), 0);
    for (int a = 0; a < 4; a++) begin strobe(1'b1, 1'b1); strobe(1'b1, 1'b1); end

    // R10: effective phase selection
    rate_third = 1'b1;
    strobe(1'b1, 1'b1); strobe(1'b1, 1'b1);
    for (int au = 0; au < 2; au++) begin
      for (int ms = 0; ms < 4; ms++) begin
        @(negedge clk);
        auto_en = au[0]; manual_sync = 2'(ms);
        #1;
        chk("R10", "effective phase", int'(sync_eff), au ? m_state : ms);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule